// File: doc/BRIEF.md
# Warp Load Coalescer

This block turns one load request from a 32-lane warp into the smallest set of memory transactions that covers it. Every lane brings a byte address, and an active mask picks which lanes take part. A single width flag selects either 4-byte words or 16-byte vector accesses. Active lanes whose addresses fall in the same 128-byte aligned line are merged into one transaction. That transaction also carries a 4-bit mask that marks which 32-byte sectors of the line the merged lanes touch. A scattered pattern therefore fetches only the sectors it needs.

Transactions leave one per handshake on a valid/ready output, ordered by ascending line address. Each one names the line, its sector mask and the lanes it serves. When the last transaction of a request is taken, the block emits a one-cycle done pulse with the number of transactions issued. A vector request with any misaligned active lane is rejected with an error and produces no transactions. A request with no active lanes completes at once with a count of zero.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, req_ready_o is 1, txn_valid_o is 0 and done_o is 0; reset asserted mid-request abandons it and returns to that state.
- R2: Exactly one transaction is issued for each distinct line address (address bits 31:7) among the active lanes. Its txn_line_o equals those bits, and bit i of txn_lanes_o is set exactly for the active lanes i in that line.
- R3: Bit k of txn_sect_o is set exactly when some lane of that transaction has address bits 6:5 equal to k. In 4-byte mode the sector comes from the lane's start address, and address bits 1:0 never affect the result.
- R4: Transactions of one request leave in strictly ascending txn_line_o order.
- R5: 32 active lanes reading consecutive 4-byte words from a 128-byte boundary produce one transaction with txn_sect_o = 4'b1111 and all 32 lane bits set.
- R6: Active lanes reading 4-byte words spaced 128 bytes apart produce one transaction per active lane, up to 32.
- R7: With req_vec_i = 1, each lane covers 16 bytes. 32 lanes reading 16 contiguous bytes from a line boundary produce four full-sector transactions of 8 lanes each.
- R8: With req_vec_i = 1, an active lane with address bits 3:0 not zero makes err_o and done_o high one cycle after acceptance, with done_cnt_o = 0 and no transaction. Misaligned inactive lanes cause no error.
- R9: Inactive lanes are served by no transaction. A request with an all-zero mask gives done_o one cycle after acceptance with done_cnt_o = 0 and err_o = 0.
- R10: req_ready_o is 0 while any transaction of the current request remains. While txn_valid_o is 1 and txn_ready_i is 0, txn_line_o, txn_sect_o and txn_lanes_o hold steady.
- R11: done_o is high for one cycle, the cycle after the handshake of the last transaction, with done_cnt_o equal to the number of transactions issued (0 to 32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request taken on valid and ready |
| req_vec_i | input | 1 | 1 = 16-byte vector access, 0 = 4-byte access |
| req_mask_i | input | 32 | Active lane mask |
| req_addr_i | input | 1024 | Byte address per lane, lane i at bits 32*i+31 : 32*i |
| txn_valid_o | output | 1 | Transaction present |
| txn_ready_i | input | 1 | Downstream takes the transaction |
| txn_line_o | output | 25 | Line address (byte address bits 31:7) |
| txn_sect_o | output | 4 | Sectors of the line touched |
| txn_lanes_o | output | 32 | Lanes served by this transaction |
| done_o | output | 1 | One-cycle completion pulse |
| done_cnt_o | output | 6 | Transactions issued for the request |
| err_o | output | 1 | Misaligned vector request, valid with done_o |

## Verification
The checker assumes that a request is sampled only in its handshake cycle and that reset goes low before the first request. It also assumes that addresses in one request do not wrap past the top of the address space, which the ordering check relies on. The bench raises req_valid_i for exactly one cycle while req_ready_o is high and keeps strides and bases inside the address range, including a descending stride. It drives stall patterns on txn_ready_i so that the hold and ordering properties are exercised under backpressure.

// File: rtl/coalesce_pkg.sv
package coalesce_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } drain_state_e;
endpackage

// File: rtl/coal_min_tree.sv
// Finds the smallest key among flagged entries (N must be a power of two).
module coal_min_tree #(
  parameter int N = 32,
  parameter int W = 25
) (
  input  logic [N-1:0]        valid_i,
  input  logic [N-1:0][W-1:0] key_i,
  output logic                valid_o,
  output logic [W-1:0]        min_o
);
  localparam int LEVELS = $clog2(N);

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int CNT = N >> l;
    logic [CNT-1:0]        v;
    logic [CNT-1:0][W-1:0] k;
    if (l == 0) begin : g_leaf
      assign v = valid_i;
      assign k = key_i;
    end else begin : g_node
      for (genvar j = 0; j < CNT; j++) begin : g_cmp
        logic take_b;
        assign take_b = g_lvl[l-1].v[2*j+1] &&
                        (!g_lvl[l-1].v[2*j] ||
                         (g_lvl[l-1].k[2*j+1] < g_lvl[l-1].k[2*j]));
        assign v[j] = g_lvl[l-1].v[2*j] | g_lvl[l-1].v[2*j+1];
        assign k[j] = take_b ? g_lvl[l-1].k[2*j+1] : g_lvl[l-1].k[2*j];
      end
    end
  end

  assign valid_o = g_lvl[LEVELS].v[0];
  assign min_o   = g_lvl[LEVELS].k[0];
endmodule

// File: rtl/coal_lane_match.sv
// Selects the pending lanes on the target line and builds their sector mask.
module coal_lane_match #(
  parameter int N  = 32,
  parameter int W  = 25,
  parameter int SW = 2
) (
  input  logic [N-1:0]         act_i,
  input  logic [N-1:0][W-1:0]  line_i,
  input  logic [N-1:0][SW-1:0] sect_i,
  input  logic [W-1:0]         tgt_i,
  output logic [N-1:0]         lanes_o,
  output logic [(1<<SW)-1:0]   sect_o
);
  localparam int NSECT = 1 << SW;

  logic [N-1:0][NSECT-1:0] lane_dec;

  for (genvar i = 0; i < N; i++) begin : g_lane
    assign lanes_o[i] = act_i[i] && (line_i[i] == tgt_i);
    for (genvar s = 0; s < NSECT; s++) begin : g_sec
      assign lane_dec[i][s] = lanes_o[i] && (sect_i[i] == SW'(s));
    end
  end

  always_comb begin
    sect_o = '0;
    for (int i = 0; i < N; i++) sect_o = sect_o | lane_dec[i];
  end
endmodule

// File: rtl/coal_drain_ctrl.sv
// Accepts a request, tracks pending lanes and counts issued transactions.
module coal_drain_ctrl
  import coalesce_pkg::*;
#(
  parameter int N     = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [N-1:0]     mask_i,
  input  logic             misalign_i,
  output logic             req_ready_o,
  output logic             load_o,
  output logic             busy_o,
  output logic [N-1:0]     pend_o,
  input  logic [N-1:0]     grp_i,
  input  logic             txn_ready_i,
  output logic             done_o,
  output logic [CNT_W-1:0] done_cnt_o,
  output logic             err_o
);
  drain_state_e      state_q;
  logic [N-1:0]      pend_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;
  logic              err_q;
  logic [CNT_W-1:0]  done_cnt_q;
  logic              accept;
  logic              fire;
  logic [N-1:0]      rest;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign fire        = (state_q == ST_BUSY) && txn_ready_i;
  assign rest        = pend_q & ~grp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      pend_q     <= '0;
      cnt_q      <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      done_cnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        if (misalign_i) begin
          done_q     <= 1'b1;
          err_q      <= 1'b1;
          done_cnt_q <= '0;
        end else if (mask_i == '0) begin
          done_q     <= 1'b1;
          done_cnt_q <= '0;
        end else begin
          state_q <= ST_BUSY;
          pend_q  <= mask_i;
          cnt_q   <= '0;
        end
      end else if (fire) begin
        pend_q <= rest;
        cnt_q  <= cnt_q + CNT_W'(1);
        if (rest == '0) begin
          state_q    <= ST_IDLE;
          done_q     <= 1'b1;
          done_cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign load_o     = accept;
  assign busy_o     = (state_q == ST_BUSY);
  assign pend_o     = pend_q;
  assign done_o     = done_q;
  assign done_cnt_o = done_cnt_q;
  assign err_o      = err_q;
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES        = 32,
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 128,
  parameter int SECTOR_BYTES = 32,
  parameter int VEC_BYTES    = 16,
  localparam int LINE_OFF    = $clog2(LINE_BYTES),
  localparam int SECT_OFF    = $clog2(SECTOR_BYTES),
  localparam int SECT_W      = LINE_OFF - SECT_OFF,
  localparam int NSECT       = 1 << SECT_W,
  localparam int LINE_W      = ADDR_W - LINE_OFF,
  localparam int CNT_W       = $clog2(LANES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic                    req_vec_i,
  input  logic [LANES-1:0]        req_mask_i,
  input  logic [LANES*ADDR_W-1:0] req_addr_i,
  output logic                    txn_valid_o,
  input  logic                    txn_ready_i,
  output logic [LINE_W-1:0]       txn_line_o,
  output logic [NSECT-1:0]        txn_sect_o,
  output logic [LANES-1:0]        txn_lanes_o,
  output logic                    done_o,
  output logic [CNT_W-1:0]        done_cnt_o,
  output logic                    err_o
);
  localparam int VEC_OFF = $clog2(VEC_BYTES);

  logic [LANES-1:0][ADDR_W-1:0] addr_q;
  logic [LANES-1:0][LINE_W-1:0] lane_line;
  logic [LANES-1:0][SECT_W-1:0] lane_sect;
  logic [LANES-1:0]             lane_mis;
  logic                         misalign;
  logic                         load;
  logic                         busy;
  logic [LANES-1:0]             pend;
  logic [LANES-1:0]             grp;
  logic                         any_pend;
  logic [LINE_W-1:0]            min_line;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_mis[i]  = req_mask_i[i] && (req_addr_i[i*ADDR_W +: VEC_OFF] != '0);
    assign lane_line[i] = addr_q[i][ADDR_W-1:LINE_OFF];
    assign lane_sect[i] = addr_q[i][LINE_OFF-1:SECT_OFF];
  end

  assign misalign = req_vec_i && (lane_mis != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (load) begin
      addr_q <= req_addr_i;
    end
  end

  coal_drain_ctrl #(.N(LANES), .CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .mask_i      (req_mask_i),
    .misalign_i  (misalign),
    .req_ready_o (req_ready_o),
    .load_o      (load),
    .busy_o      (busy),
    .pend_o      (pend),
    .grp_i       (grp),
    .txn_ready_i (txn_ready_i),
    .done_o      (done_o),
    .done_cnt_o  (done_cnt_o),
    .err_o       (err_o)
  );

  coal_min_tree #(.N(LANES), .W(LINE_W)) u_min (
    .valid_i (pend),
    .key_i   (lane_line),
    .valid_o (any_pend),
    .min_o   (min_line)
  );

  coal_lane_match #(.N(LANES), .W(LINE_W), .SW(SECT_W)) u_match (
    .act_i   (pend),
    .line_i  (lane_line),
    .sect_i  (lane_sect),
    .tgt_i   (min_line),
    .lanes_o (grp),
    .sect_o  (txn_sect_o)
  );

  assign txn_valid_o = busy && any_pend;
  assign txn_line_o  = min_line;
  assign txn_lanes_o = grp;
endmodule

// File: rtl/warp_coalescer_chk.sv
module warp_coalescer_chk #(
  parameter int LANES  = 32,
  parameter int LINE_W = 25,
  parameter int NSECT  = 4,
  parameter int CNT_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              txn_valid_o,
  input logic              txn_ready_i,
  input logic [LINE_W-1:0] txn_line_o,
  input logic [NSECT-1:0]  txn_sect_o,
  input logic [LANES-1:0]  txn_lanes_o,
  input logic              done_o,
  input logic [CNT_W-1:0]  done_cnt_o,
  input logic              err_o
);
  logic              first_q;
  logic [LINE_W-1:0] last_line_q;
  logic [LANES-1:0]  served_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q     <= 1'b1;
      last_line_q <= '0;
      served_q    <= '0;
    end else if (req_valid_i && req_ready_o) begin
      first_q  <= 1'b1;
      served_q <= '0;
    end else if (txn_valid_o && txn_ready_i) begin
      first_q     <= 1'b0;
      last_line_q <= txn_line_o;
      served_q    <= served_q | txn_lanes_o;
    end
  end

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && !txn_ready_i |=> txn_valid_o && $stable(txn_line_o) &&
    $stable(txn_sect_o) && $stable(txn_lanes_o));

  assert_busy_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> !req_ready_o);

  assert_sector_nonempty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> (txn_sect_o != '0) && (txn_lanes_o != '0));

  assert_ascending_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && !first_q |-> txn_line_o > last_line_q);

  assert_disjoint_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> (txn_lanes_o & served_q) == '0);

  assert_err_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o && (done_cnt_o == '0));

  assert_cnt_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> done_cnt_o <= CNT_W'(LANES));

  assert_done_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !txn_valid_o);
endmodule

bind warp_coalescer warp_coalescer_chk #(
  .LANES(LANES), .LINE_W(LINE_W), .NSECT(NSECT), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/warp_coalescer_tb_top.sv
`timescale 1ns/1ps
module warp_coalescer_tb_top;
  localparam int L = 32;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] stride;
    logic [31:0] mask;
    logic        vec;
    logic        bp;
    logic [5:0]  cnt;
    logic        err;
    logic [3:0]  sec0;
    logic [31:0] lanes0;
  } vec_t;

  // R5, R6, R7, R8, R9, R3, R4, R2 patterns
  localparam vec_t VECS [12] = '{
    '{32'h0000_1000, 32'd4,         32'hFFFF_FFFF, 1'b0, 1'b0, 6'd1,  1'b0, 4'hF, 32'hFFFF_FFFF},
    '{32'h0000_2000, 32'd128,       32'hFFFF_FFFF, 1'b0, 1'b1, 6'd32, 1'b0, 4'h1, 32'h0000_0001},
    '{32'h0000_4000, 32'd16,        32'hFFFF_FFFF, 1'b1, 1'b1, 6'd4,  1'b0, 4'hF, 32'h0000_00FF},
    '{32'h0000_4008, 32'd16,        32'hFFFF_FFFF, 1'b1, 1'b0, 6'd0,  1'b1, 4'h0, 32'h0000_0000},
    '{32'h0000_5000, 32'd4,         32'h0000_0000, 1'b0, 1'b0, 6'd0,  1'b0, 4'h0, 32'h0000_0000},
    '{32'h0000_0000, 32'd128,       32'h0000_000F, 1'b0, 1'b0, 6'd4,  1'b0, 4'h1, 32'h0000_0001},
    '{32'h0000_0100, 32'd64,        32'hFFFF_FFFF, 1'b0, 1'b1, 6'd16, 1'b0, 4'h5, 32'h0000_0003},
    '{32'h0000_8F80, 32'hFFFF_FF80, 32'hFFFF_FFFF, 1'b0, 1'b1, 6'd32, 1'b0, 4'h1, 32'h8000_0000},
    '{32'h0000_4000, 32'd24,        32'h5555_5555, 1'b1, 1'b0, 6'd6,  1'b0, 4'hB, 32'h0000_0015},
    '{32'h0000_4000, 32'd24,        32'h5555_5557, 1'b1, 1'b0, 6'd0,  1'b1, 4'h0, 32'h0000_0000},
    '{32'h0000_3003, 32'd4,         32'hFFFF_FFFF, 1'b0, 1'b1, 6'd1,  1'b0, 4'hF, 32'hFFFF_FFFF},
    '{32'h0000_01F0, 32'd4,         32'hFFFF_FFFF, 1'b0, 1'b0, 6'd2,  1'b0, 4'h8, 32'h0000_000F}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic          req_vec_i = 1'b0;
  logic [L-1:0]  req_mask_i = '0;
  logic [L*32-1:0] req_addr_i = '0;
  logic          txn_valid_o;
  logic          txn_ready_i = 1'b1;
  logic [24:0]   txn_line_o;
  logic [3:0]    txn_sect_o;
  logic [L-1:0]  txn_lanes_o;
  logic          done_o;
  logic [5:0]    done_cnt_o;
  logic          err_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  warp_coalescer dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] lane_addr(input vec_t v, input int i);
    return v.base + v.stride * i;
  endfunction

  task automatic run_vec(input int idx);
    vec_t v;
    int n;
    bit held;
    bit got_done;
    logic [24:0] prev_line, h_line;
    logic [3:0]  h_sect, sec0;
    logic [31:0] h_lanes, lanes0, seen;
    v = VECS[idx];
    n = 0; held = 0; got_done = 0; seen = '0; sec0 = '0; lanes0 = '0; prev_line = '0;
    h_line = '0; h_sect = '0; h_lanes = '0;
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R10", $sformatf("v%0d ready before request", idx), 32'(req_ready_o), 32'd1);
    for (int i = 0; i < L; i++) req_addr_i[i*32 +: 32] = lane_addr(v, i);
    req_mask_i  = v.mask;
    req_vec_i   = v.vec;
    req_valid_i = 1'b1;
    txn_ready_i = 1'b1;
    @(posedge clk_i);
    #1 req_valid_i = 1'b0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk_i);
      if (done_o) begin
        got_done = 1;
        break;
      end
      if (txn_valid_o) begin
        chk(!req_ready_o, "R10", $sformatf("v%0d ready low while draining", idx), 32'(req_ready_o), 32'd0);
        if (held) begin
          chk({txn_line_o, txn_sect_o} == {h_line, h_sect} && txn_lanes_o == h_lanes, "R10",
              $sformatf("v%0d output held under stall", idx), txn_lanes_o, h_lanes);
        end
        if (v.bp && (c % 3 == 1)) begin
          txn_ready_i = 1'b0;
          held = 1; h_line = txn_line_o; h_sect = txn_sect_o; h_lanes = txn_lanes_o;
        end else begin
          logic [31:0] exp_lanes;
          logic [3:0]  exp_sect;
          txn_ready_i = 1'b1;
          held = 0;
          exp_lanes = '0; exp_sect = '0;
          for (int i = 0; i < L; i++) begin
            logic [31:0] a;
            a = lane_addr(v, i);
            if (v.mask[i] && a[31:7] == txn_line_o) begin
              exp_lanes[i] = 1'b1;
              exp_sect[a[6:5]] = 1'b1;
            end
          end
          n++;
          if (n == 1) begin
            sec0 = txn_sect_o; lanes0 = txn_lanes_o;
          end else begin
            chk(txn_line_o > prev_line, "R4", $sformatf("v%0d ascending line", idx),
                32'(txn_line_o), 32'(prev_line));
          end
          chk(txn_lanes_o == exp_lanes, "R2", $sformatf("v%0d lanes of line", idx), txn_lanes_o, exp_lanes);
          chk(txn_sect_o == exp_sect, "R3", $sformatf("v%0d sector mask", idx), 32'(txn_sect_o), 32'(exp_sect));
          chk((txn_lanes_o & seen) == '0, "R2", $sformatf("v%0d lane served once", idx), txn_lanes_o & seen, 32'd0);
          seen = seen | txn_lanes_o;
          prev_line = txn_line_o;
        end
      end else begin
        txn_ready_i = 1'b1;
        held = 0;
      end
    end
    chk(got_done, "R11", $sformatf("v%0d done seen", idx), 32'(got_done), 32'd1);
    chk(done_cnt_o == v.cnt, "R11", $sformatf("v%0d done count", idx), 32'(done_cnt_o), 32'(v.cnt));
    chk(n == int'(v.cnt), "R2", $sformatf("v%0d transactions issued", idx), 32'(n), 32'(v.cnt));
    chk(err_o == v.err, "R8", $sformatf("v%0d error flag", idx), 32'(err_o), 32'(v.err));
    chk(sec0 == v.sec0, "R3", $sformatf("v%0d first sector mask", idx), 32'(sec0), 32'(v.sec0));
    chk(lanes0 == v.lanes0, "R2", $sformatf("v%0d first lanes", idx), lanes0, v.lanes0);
    chk(seen == (v.err ? 32'd0 : v.mask), "R9", $sformatf("v%0d lanes covered equal active", idx),
        seen, v.err ? 32'd0 : v.mask);
    @(negedge clk_i);
    chk(!done_o, "R11", $sformatf("v%0d done single cycle", idx), 32'(done_o), 32'd0);
    txn_ready_i = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(req_ready_o == 1'b1, "R1", "ready after reset", 32'(req_ready_o), 32'd1);
    chk(txn_valid_o == 1'b0, "R1", "valid after reset", 32'(txn_valid_o), 32'd0);
    chk(done_o == 1'b0, "R1", "done after reset", 32'(done_o), 32'd0);

    for (int k = 0; k < 12; k++) run_vec(k);

    // R1 reset during a stalled request
    @(negedge clk_i);
    for (int i = 0; i < L; i++) req_addr_i[i*32 +: 32] = 32'h0000_6000 + 32'(i) * 32'd128;
    req_mask_i = '1; req_vec_i = 1'b0; req_valid_i = 1'b1; txn_ready_i = 1'b0;
    @(posedge clk_i);
    #1 req_valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(txn_valid_o == 1'b1, "R10", "stalled request pending", 32'(txn_valid_o), 32'd1);
    rst_ni = 1'b0;
    #1;
    chk(txn_valid_o == 1'b0, "R1", "valid cleared by reset", 32'(txn_valid_o), 32'd0);
    chk(req_ready_o == 1'b1, "R1", "ready restored by reset", 32'(req_ready_o), 32'd1);
    @(negedge clk_i);
    rst_ni = 1'b1; txn_ready_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(done_o == 1'b0, "R1", "no done after abandoned request", 32'(done_o), 32'd0);

    run_vec(0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule